// File: doc/BRIEF.md
# Programmable Tick Clock

This peripheral gives a 16-bit processor a periodic time base. A free-running divider turns the system clock into a 60 Hz base tick. A second, programmable divider passes one tick for every B base ticks, so the output rate is 60/B ticks per second. The peripheral counts the ticks it has produced since it was last configured. When software has armed it with a nonzero message, it raises an interrupt carrying that message on every tick.

The processor drives a one-cycle command strobe together with its A and B register values. The value of A selects the operation:

- A=0 sets the rate.
- A=1 reads the tick count back into a C result register.
- A=2 sets or clears the interrupt message.

The block also presents a fixed 32-bit identifier and a 16-bit version for device discovery.

Top module: `tick_clock`

## Requirements
- R1: After reset, `irq` is 0, `irq_msg` is 0 and `rsp_c` is 0. The clock is off, and interrupts are disabled.
- R2: A command with `cmd_a`=0 stores `cmd_b` as the divide ratio and clears the tick count. It also restarts both the base divider and the ratio divider from zero, so the first tick lands exactly `BASE_DIV*cmd_b` clock edges after the command edge.
- R3: A rate command with `cmd_b`=0 stops ticking. The count then stays at 0 and no interrupt is raised.
- R4: A command with `cmd_a`=1 loads `rsp_c` with the tick count as it stood before that edge. `rsp_c` holds that value until the next such command.
- R5: The tick count saturates at 0xffff and does not wrap.
- R6: A command with `cmd_a`=2 and nonzero `cmd_b` enables interrupts with `cmd_b` as the message. After that, each tick raises `irq` for exactly one cycle, one edge after the tick, and `irq_msg` equals the message during that cycle.
- R7: A command with `cmd_a`=2 and `cmd_b`=0 disables interrupts. Ticks then continue to be counted, but no `irq` is raised.
- R8: A command whose 16-bit `cmd_a` is greater than 2 is ignored. It changes neither the rate, the message, the tick count nor `rsp_c`.
- R9: `dev_id` reads 0x12d0b402 and `dev_ver` reads 1.
- R10: A base tick occurs once every `BASE_DIV` system clock cycles, where `BASE_DIV` is the system clock frequency divided by 60.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_a | input | 16 | Command selector (processor A value) |
| cmd_b | input | 16 | Command argument (processor B value) |
| rsp_c | output | 16 | Tick count captured by the last read command |
| irq | output | 1 | One-cycle interrupt request per tick while armed |
| irq_msg | output | 16 | Message carried by the interrupt |
| dev_id | output | 32 | Fixed device identifier |
| dev_ver | output | 16 | Fixed device version |

## Verification
The assertions watch the following on every cycle:

- The interrupt is a single-cycle pulse with a nonzero message.
- No interrupt occurs while the rate is zero.
- The count never steps by more than one.
- The count sticks at 0xffff.
- A rate command always clears the count.
- Out-of-range commands leave the rate and message registers unchanged.

Only the bench's scenarios can show the exact tick spacing for a given ratio, the number of interrupts in a window, and the value returned by a read command. Those scenarios also show that disabling interrupts silences `irq` while counting goes on, and that the count actually reaches 0xffff after a long run.

// File: rtl/tick_clock.sv
module tick_clock #(
  parameter int unsigned BASE_DIV = 2083333,
  parameter logic [31:0] DEV_ID   = 32'h12d0b402,
  parameter logic [15:0] DEV_VER  = 16'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [15:0] cmd_a,
  input  logic [15:0] cmd_b,
  output logic [15:0] rsp_c,
  output logic        irq,
  output logic [15:0] irq_msg,
  output logic [31:0] dev_id,
  output logic [15:0] dev_ver
);

  localparam int BW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam logic [BW-1:0] BASE_LAST = BW'(BASE_DIV - 1);
  localparam logic [15:0] CNT_MAX = 16'hffff;

  logic [BW-1:0] base_cnt;
  logic [15:0]   rate_q, presc_q, count_q, msg_q;

  wire cmd_set  = cmd_valid && (cmd_a == 16'd0);
  wire cmd_read = cmd_valid && (cmd_a == 16'd1);
  wire cmd_arm  = cmd_valid && (cmd_a == 16'd2);

  wire base_tick = (base_cnt == BASE_LAST);
  wire running   = (rate_q != 16'd0);
  wire tick      = !cmd_set && base_tick && running && (presc_q == rate_q - 16'd1);

  assign dev_id  = DEV_ID;
  assign dev_ver = DEV_VER;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_cnt <= '0;
      presc_q  <= '0;
      rate_q   <= '0;
      count_q  <= '0;
    end else if (cmd_set) begin
      base_cnt <= '0;
      presc_q  <= '0;
      rate_q   <= cmd_b;
      count_q  <= '0;
    end else begin
      base_cnt <= base_tick ? '0 : base_cnt + 1'b1;
      if (base_tick && running)
        presc_q <= tick ? 16'd0 : presc_q + 16'd1;
      if (tick && count_q != CNT_MAX)
        count_q <= count_q + 16'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_q   <= '0;
      rsp_c   <= '0;
      irq     <= 1'b0;
      irq_msg <= '0;
    end else begin
      if (cmd_arm)  msg_q <= cmd_b;
      if (cmd_read) rsp_c <= count_q;
      irq <= tick && (msg_q != 16'd0);
      if (tick) irq_msg <= msg_q;
    end
  end

endmodule

// File: rtl/tick_clock_chk.sv
module tick_clock_chk #(
  parameter int unsigned BASE_DIV = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [15:0] cmd_a,
  input logic [15:0] rate_q,
  input logic [15:0] msg_q,
  input logic [15:0] count_q,
  input logic        irq,
  input logic [15:0] irq_msg
);

  wire set_cmd = cmd_valid && (cmd_a == 16'd0);

  a_r6_msg_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_msg != 16'd0));

  generate
    if (BASE_DIV > 1) begin : g_pulse
      a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    end
  endgenerate

  a_r3_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == 16'd0) |=> !irq);

  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    set_cmd |=> (count_q == 16'd0));

  a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == 16'hffff && !set_cmd) |=> (count_q == 16'hffff));

  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    !set_cmd |=> (count_q == $past(count_q) || count_q == $past(count_q) + 16'd1));

  a_r8_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_a > 16'd2) |=> ($stable(rate_q) && $stable(msg_q)));

endmodule

bind tick_clock tick_clock_chk #(.BASE_DIV(BASE_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_a(cmd_a),
  .rate_q(rate_q), .msg_q(msg_q), .count_q(count_q),
  .irq(irq), .irq_msg(irq_msg)
);

// File: tb/tick_clock_tb.sv
module tick_clock_tb;
  localparam int unsigned DIV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [15:0] cmd_a = '0, cmd_b = '0;
  logic [15:0] rsp_c, irq_msg, dev_ver;
  logic [31:0] dev_id;
  logic irq;

  int checks = 0, failures = 0, irq_cnt = 0;
  logic [15:0] last_msg = '0;
  bit done = 0;

  always #4 clk = ~clk;

  tick_clock #(.BASE_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_a(cmd_a), .cmd_b(cmd_b),
    .rsp_c(rsp_c), .irq(irq), .irq_msg(irq_msg), .dev_id(dev_id), .dev_ver(dev_ver)
  );

  always @(negedge clk) if (rst_n && irq) begin
    irq_cnt++;
    last_msg = irq_msg;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [15:0] a, input logic [15:0] b);
    cmd_valid = 1'b1; cmd_a = a; cmd_b = b;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_a = '0; cmd_b = '0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] ticks(input int edges, input int ratio);
    int t = edges / (DIV * ratio);
    return (t > 65535) ? 16'hffff : 16'(t);
  endfunction

  task automatic t_reset;
    check("R1 irq", irq, 0);
    check("R1 irq_msg", irq_msg, 0);
    check("R1 rsp_c", rsp_c, 0);
    check("R9 dev_id", dev_id, 32'h12d0b402);
    check("R9 dev_ver", dev_ver, 1);
    wait_cyc(20);
    do_cmd(16'd1, 16'd0);
    check("R3 off after reset", rsp_c, 0);
  endtask

  task automatic t_rate;
    do_cmd(16'd0, 16'd3); wait_cyc(25); do_cmd(16'd1, 0);
    check("R2 ratio 3", rsp_c, ticks(25, 3));
    do_cmd(16'd0, 16'd1); wait_cyc(9); do_cmd(16'd1, 0);
    check("R10 ratio 1", rsp_c, ticks(9, 1));
    do_cmd(16'd0, 16'd1); wait_cyc(1); do_cmd(16'd1, 0);
    check("R10 before first base tick", rsp_c, 0);
    do_cmd(16'd0, 16'd5); do_cmd(16'd1, 0);
    check("R2 cleared on set", rsp_c, 0);
    wait_cyc(30);
    check("R4 rsp_c holds", rsp_c, 0);
  endtask

  task automatic t_off;
    do_cmd(16'd2, 16'h1234);
    do_cmd(16'd0, 16'd0);
    irq_cnt = 0;
    wait_cyc(40); do_cmd(16'd1, 0);
    check("R3 count stays 0", rsp_c, 0);
    check("R3 no irq", irq_cnt, 0);
  endtask

  task automatic t_irq;
    do_cmd(16'd2, 16'h55aa);
    irq_cnt = 0;
    do_cmd(16'd0, 16'd3);
    wait_cyc(20);
    check("R6 irq pulses", irq_cnt, 3);
    check("R6 irq message", last_msg, 16'h55aa);
    do_cmd(16'd0, 16'd3);
    do_cmd(16'd2, 16'd0);
    irq_cnt = 0;
    wait_cyc(20);
    check("R7 no irq when disabled", irq_cnt, 0);
    do_cmd(16'd1, 0);
    check("R7 still counting", rsp_c, ticks(21, 3));
  endtask

  task automatic t_ignore;
    do_cmd(16'd2, 16'h0f0f);
    do_cmd(16'd0, 16'd2);
    irq_cnt = 0;
    do_cmd(16'd5, 16'd0);
    do_cmd(16'hffff, 16'd7);
    do_cmd(16'd3, 16'd1);
    check("R8 rsp_c untouched", rsp_c, ticks(21, 3));
    wait_cyc(10);
    do_cmd(16'd1, 0);
    check("R8 rate and count kept", rsp_c, ticks(13, 2));
    check("R8 irq count", irq_cnt, 3);
    check("R8 message kept", last_msg, 16'h0f0f);
  endtask

  task automatic t_sat;
    do_cmd(16'd2, 16'd0);
    do_cmd(16'd0, 16'd1);
    wait_cyc(140000);
    do_cmd(16'd1, 0);
    check("R5 saturates", rsp_c, 16'hffff);
    do_cmd(16'd0, 16'd1); do_cmd(16'd1, 0);
    check("R2 clear after saturation", rsp_c, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rate();
    t_off();
    t_irq();
    t_ignore();
    t_sat();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule